// File: doc/BRIEF.md
# Dual Wiper Register Bank with Non-Volatile Shadow

This block is the register map behind a two-channel digital potentiometer. Each channel has a live 7-bit wiper code and a stored initial code that survives power cycling. Five general-purpose stored bytes and one control register sit beside them. A serial front end, which is not part of this block, decodes the wire protocol. It presents one byte read or write per cycle and pulses a strobe when the host closes the transaction. The block returns read data one cycle later. It drives the two wiper codes and a shutdown flag to the analog array.

Stored bytes are modelled as registers. Their contents at reset come from a parameter that acts as the factory image. A write to a stored byte is held in a single staging slot. It is committed when the transaction ends, by a self-timed cycle that lasts `COMMIT_CYCLES` clocks. The commit cycle raises a busy flag and refuses every write while it runs. A control bit decides whether channel addresses reach the live wiper or the stored copy. After reset both wipers sit at mid-scale (40h). After `RECALL_CYCLES` clocks they load their stored codes.

Top module: `potbank_regs`

## Requirements
- R1: After reset, both wiper outputs are 40h and `shutdown` is 0. A read of the control register (address 8) returns 40h: bit 7 (volatile select) is 0, bit 6 (run, active-low shutdown enable) is 1, and bit 5 (busy) is 0.
- R2: Exactly `RECALL_CYCLES` clocks after reset, each channel's live wiper loads the low 7 bits of its stored initial code. Writes presented before that point are refused and leave no trace.
- R3: A write to address 8 sets bit 7 and bit 6 from the written byte. Reads of address 8 return {select, run, busy, 00000b}, so bits 4 to 0 read 0 whatever was written.
- R4: With select = 1, a write to address 0 (channel 0) or 1 (channel 1) changes only that channel's live wiper. The stored code stays as it was, no commit starts, and a read of the address returns {0, live wiper}.
- R5: With select = 0, a write to address 0 or 1 loads data[6:0] into the live wiper at once and stages {0, data[6:0]} for the stored code. A read with select = 0 returns the stored code.
- R6: Addresses 2 to 6 are full 8-bit stored bytes with no live copy. They are written and read the same way for either value of select.
- R7: A commit starts on the clock that samples `txn_end` while a byte is staged. Busy then reads 1 for exactly `COMMIT_CYCLES` cycles. The stored byte takes its new value when busy falls, and reads before that return the old value.
- R8: While busy is 1, writes to every address (control register, wipers, stored bytes) are refused, and reads still work.
- R9: Only the first stored-byte write in a transaction is accepted. Later ones in the same transaction are ignored, and this includes the live-wiper load of a select = 0 channel write.
- R10: `shutdown` is 1 when control bit 6 is 0 or `shdn_pin_n` is low. During shutdown both wiper outputs are 00h, while registers keep their values and stay writable. Leaving shutdown restores the held codes.
- R11: Addresses 7 and 9 to 15 read as 00h. Writes to them change nothing and start no commit.
- R12: A read request sampled on one clock gives `rd_valid` = 1 with its data after that clock. `rd_valid` is 0 after any clock that sampled no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, also the power-up event |
| req_valid | input | 1 | A byte access is presented this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register address |
| req_wdata | input | 8 | Write data |
| txn_end | input | 1 | Strobe: the host closed the transaction |
| shdn_pin_n | input | 1 | External active-low shutdown |
| rd_valid | output | 1 | Read data is valid |
| rd_data | output | 8 | Read data |
| wiper_codes | output | 14 | Channel 1 code in [13:7], channel 0 code in [6:0] |
| shutdown | output | 1 | Array is in shutdown |

## Verification
If the select bit is wrong, the ports show it the next time a channel is written. The wrong copy changes: either the wiper output moves when it should not, or the stored read-back differs, within one cycle. A broken staging slot or commit timer does not show at once. It shows `COMMIT_CYCLES` later, when a stored byte read back holds the old value, a value from a later write, or changes at the wrong cycle. The bench therefore reads busy on the last busy cycle and on the first idle cycle. A stuck busy flag or a missed refusal shows as a wiper output or control value that changed during the commit window.

// File: rtl/potbank_pkg.sv
package potbank_pkg;
    localparam int unsigned DATA_W   = 8;
    localparam int unsigned ADDR_W   = 4;
    localparam int unsigned WIPER_W  = 7;
    localparam int unsigned NUM_CH   = 2;
    localparam int unsigned NUM_GP   = 5;
    localparam int unsigned NV_DEPTH = NUM_CH + NUM_GP;
    localparam int unsigned NV_IDX_W = $clog2(NV_DEPTH);
    localparam int unsigned PAD_W    = DATA_W - WIPER_W;

    localparam logic [ADDR_W-1:0]  CTRL_ADDR = ADDR_W'(8);
    localparam logic [WIPER_W-1:0] WIPER_MID = WIPER_W'(7'h40);

    localparam int unsigned SEL_BIT  = 7;
    localparam int unsigned RUN_BIT  = 6;
    localparam int unsigned BUSY_BIT = 5;
endpackage

// File: rtl/potbank_recall.sv
module potbank_recall #(
    parameter int unsigned RECALL_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic load_o,
    output logic done_o
);
    localparam int unsigned CNT_W = $clog2(RECALL_CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } rc_state_t;

    rc_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        load_o = 1'b0;
        if (!s_q.done) begin
            if (s_q.cnt == CNT_W'(RECALL_CYCLES - 1)) begin
                s_d.done = 1'b1;
                load_o   = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done_o = s_q.done;
endmodule

// File: rtl/potbank_wiper.sv
module potbank_wiper
    import potbank_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               recall_i,
    input  logic [WIPER_W-1:0] recall_val_i,
    input  logic               wr_i,
    input  logic [WIPER_W-1:0] wr_val_i,
    input  logic               shutdown_i,
    output logic [WIPER_W-1:0] raw_o,
    output logic [WIPER_W-1:0] code_o
);
    typedef struct packed {
        logic [WIPER_W-1:0] code;
    } wp_state_t;

    wp_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (recall_i)  s_d.code = recall_val_i;
        else if (wr_i) s_d.code = wr_val_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q.code <= WIPER_MID;
        else        s_q      <= s_d;
    end

    assign raw_o  = s_q.code;
    assign code_o = shutdown_i ? '0 : s_q.code;
endmodule

// File: rtl/potbank_nvstore.sv
module potbank_nvstore
    import potbank_pkg::*;
#(
    parameter int unsigned                     COMMIT_CYCLES = 2000000,
    parameter logic [NUM_CH*WIPER_W-1:0]       IVR_INIT      = {NUM_CH{WIPER_MID}}
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               stage_i,
    input  logic [NV_IDX_W-1:0]                stage_idx_i,
    input  logic [DATA_W-1:0]                  stage_data_i,
    input  logic                               txn_end_i,
    output logic                               busy_o,
    output logic                               staged_o,
    output logic [NV_DEPTH-1:0][DATA_W-1:0]    bank_o
);
    localparam int unsigned CNT_W = $clog2(COMMIT_CYCLES + 1);

    typedef struct packed {
        logic [NV_DEPTH-1:0][DATA_W-1:0] mem;
        logic                            pend;
        logic [NV_IDX_W-1:0]             pidx;
        logic [DATA_W-1:0]               pdata;
        logic                            busy;
        logic [CNT_W-1:0]                cnt;
    } nv_state_t;

    nv_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        // first accepted write of the transaction takes the single slot
        if (stage_i && !s_q.pend && !s_q.busy) begin
            s_d.pend  = 1'b1;
            s_d.pidx  = stage_idx_i;
            s_d.pdata = stage_data_i;
        end
        if (s_q.busy) begin
            if (s_q.cnt == CNT_W'(1)) begin
                s_d.busy            = 1'b0;
                s_d.cnt             = '0;
                s_d.mem[s_q.pidx]   = s_q.pdata;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end else if (txn_end_i) begin
            if (s_d.pend) begin
                s_d.busy = 1'b1;
                s_d.cnt  = CNT_W'(COMMIT_CYCLES);
            end
            s_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int c = 0; c < NUM_CH; c++) begin
                s_q.mem[c] <= {{PAD_W{1'b0}}, IVR_INIT[c*WIPER_W +: WIPER_W]};
            end
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o   = s_q.busy;
    assign staged_o = s_q.pend;
    assign bank_o   = s_q.mem;
endmodule

// File: rtl/potbank_regs.sv
module potbank_regs
    import potbank_pkg::*;
#(
    parameter int unsigned               COMMIT_CYCLES = 2000000,
    parameter int unsigned               RECALL_CYCLES = 1000,
    parameter logic [NUM_CH*WIPER_W-1:0] IVR_INIT      = {NUM_CH{WIPER_MID}}
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [DATA_W-1:0]           req_wdata,
    input  logic                        txn_end,
    input  logic                        shdn_pin_n,
    output logic                        rd_valid,
    output logic [DATA_W-1:0]           rd_data,
    output logic [NUM_CH*WIPER_W-1:0]   wiper_codes,
    output logic                        shutdown
);
    typedef struct packed {
        logic              sel;
        logic              run;
        logic              rd_valid;
        logic [DATA_W-1:0] rd_data;
    } top_state_t;

    top_state_t s_d, s_q;

    logic                              recall_load, recall_done;
    logic                              nv_busy, nv_staged, nv_stage;
    logic [NV_IDX_W-1:0]               nv_idx;
    logic [DATA_W-1:0]                 nv_data;
    logic [NV_DEPTH-1:0][DATA_W-1:0]   nv_bank;
    logic [NUM_CH-1:0]                 wip_wr;
    logic [NUM_CH-1:0][WIPER_W-1:0]    wiper_raw;
    logic [NUM_CH*WIPER_W-1:0]         wiper_raw_flat;

    logic is_ch, is_gp, is_ctrl, wr_ok, nv_class;

    // address classes
    assign is_ch   = req_addr < ADDR_W'(NUM_CH);
    assign is_gp   = (req_addr >= ADDR_W'(NUM_CH)) && (req_addr < ADDR_W'(NV_DEPTH));
    assign is_ctrl = req_addr == CTRL_ADDR;

    // write gate: recall finished and no commit cycle running
    assign wr_ok    = req_valid && req_write && recall_done && !nv_busy;
    assign nv_class = is_gp || (is_ch && !s_q.sel);
    assign nv_stage = wr_ok && nv_class && !nv_staged;
    assign nv_idx   = req_addr[NV_IDX_W-1:0];
    assign nv_data  = is_ch ? {{PAD_W{1'b0}}, req_wdata[WIPER_W-1:0]} : req_wdata;

    assign shutdown = !s_q.run || !shdn_pin_n;

    always_comb begin
        s_d          = s_q;
        s_d.rd_valid = req_valid && !req_write;
        s_d.rd_data  = '0;
        wip_wr       = '0;

        for (int c = 0; c < NUM_CH; c++) begin
            if (req_addr == ADDR_W'(c)) begin
                wip_wr[c] = wr_ok && (s_q.sel || nv_stage);
            end
        end

        if (wr_ok && is_ctrl) begin
            s_d.sel = req_wdata[SEL_BIT];
            s_d.run = req_wdata[RUN_BIT];
        end

        if (req_valid && !req_write) begin
            if (is_ctrl) begin
                s_d.rd_data[SEL_BIT]  = s_q.sel;
                s_d.rd_data[RUN_BIT]  = s_q.run;
                s_d.rd_data[BUSY_BIT] = nv_busy;
            end else if (is_ch && s_q.sel) begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (req_addr == ADDR_W'(c)) begin
                        s_d.rd_data = {{PAD_W{1'b0}}, wiper_raw[c]};
                    end
                end
            end else if (is_ch || is_gp) begin
                s_d.rd_data = nv_bank[nv_idx];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q     <= '0;
            s_q.run <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_valid = s_q.rd_valid;
    assign rd_data  = s_q.rd_data;

    potbank_recall #(
        .RECALL_CYCLES(RECALL_CYCLES)
    ) u_recall (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_o (recall_load),
        .done_o (recall_done)
    );

    potbank_nvstore #(
        .COMMIT_CYCLES(COMMIT_CYCLES),
        .IVR_INIT     (IVR_INIT)
    ) u_nv (
        .clk          (clk),
        .rst_n        (rst_n),
        .stage_i      (nv_stage),
        .stage_idx_i  (nv_idx),
        .stage_data_i (nv_data),
        .txn_end_i    (txn_end),
        .busy_o       (nv_busy),
        .staged_o     (nv_staged),
        .bank_o       (nv_bank)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        potbank_wiper u_wiper (
            .clk          (clk),
            .rst_n        (rst_n),
            .recall_i     (recall_load),
            .recall_val_i (nv_bank[c][WIPER_W-1:0]),
            .wr_i         (wip_wr[c]),
            .wr_val_i     (req_wdata[WIPER_W-1:0]),
            .shutdown_i   (shutdown),
            .raw_o        (wiper_raw[c]),
            .code_o       (wiper_codes[c*WIPER_W +: WIPER_W])
        );
        assign wiper_raw_flat[c*WIPER_W +: WIPER_W] = wiper_raw[c];
    end
endmodule

// File: rtl/potbank_regs_chk.sv
module potbank_regs_chk
    import potbank_pkg::*;
(
    input logic                      clk,
    input logic                      rst_n,
    input logic                      req_valid,
    input logic                      req_write,
    input logic [ADDR_W-1:0]         req_addr,
    input logic                      txn_end,
    input logic                      rd_valid,
    input logic [DATA_W-1:0]         rd_data,
    input logic                      shutdown,
    input logic [NUM_CH*WIPER_W-1:0] wiper_codes,
    input logic                      busy,
    input logic [NUM_CH*WIPER_W-1:0] wiper_raw
);
    AST_SHDN_GROUNDS_WIPERS: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> (wiper_codes == '0)); // R10

    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid); // R12

    AST_NO_SPURIOUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid); // R12

    AST_CTRL_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == CTRL_ADDR) |=> (rd_data[4:0] == 5'd0)); // R3

    AST_BUSY_FREEZES_WIPERS: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(wiper_raw)); // R8

    AST_COMMIT_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(txn_end)); // R7
endmodule

bind potbank_regs potbank_regs_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .txn_end     (txn_end),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .shutdown    (shutdown),
    .wiper_codes (wiper_codes),
    .busy        (nv_busy),
    .wiper_raw   (wiper_raw_flat)
);

// File: tb/potbank_regs_bench.sv
module potbank_regs_bench;
    localparam int unsigned COMMIT = 20;
    localparam int unsigned RECALL = 8;
    localparam logic [13:0] INIT   = {7'h5A, 7'h25};

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0, txn_end = 1'b0, shdn_pin_n = 1'b1;
    logic [3:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       rd_valid, shutdown;
    logic [7:0] rd_data;
    logic [13:0] wiper_codes;

    int n_run = 0, n_fail = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    potbank_regs #(
        .COMMIT_CYCLES(COMMIT),
        .RECALL_CYCLES(RECALL),
        .IVR_INIT     (INIT)
    ) u_potbank_regs (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .txn_end(txn_end),
        .shdn_pin_n(shdn_pin_n), .rd_valid(rd_valid), .rd_data(rd_data),
        .wiper_codes(wiper_codes), .shutdown(shutdown)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic chk_wipers(input string tag, input logic [6:0] e0, input logic [6:0] e1);
        chk({tag, " ch0"}, {1'b0, wiper_codes[6:0]}, {1'b0, e0});
        chk({tag, " ch1"}, {1'b0, wiper_codes[13:7]}, {1'b0, e1});
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic endt();
        txn_end = 1'b1;
        @(negedge clk);
        txn_end = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                n_run++; n_fail++;
                $display("FAIL R12 unexpected read data: actual %02h expected none", rd_data);
            end else begin
                chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (exp_q.size() != 0) begin
            n_run++; n_fail++;
            $display("FAIL R12 missing read data: actual %0d pending expected 0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_wipers("R1 reset wipers", 7'h40, 7'h40);
        chk("R1 reset shutdown", {7'd0, shutdown}, 8'h00);
        rd(4'd8, 8'h40, "R1 reset ctrl");
        // R2 write before recall is refused
        wr(4'd2, 8'h55);
        chk("R12 idle after write", {7'd0, rd_valid}, 8'h00);
        repeat (RECALL) @(negedge clk);
        chk_wipers("R2 recalled wipers", 7'h25, 7'h5A);
        rd(4'd2, 8'h00, "R2 early write refused");

        // R3 control register
        wr(4'd8, 8'hFF);
        rd(4'd8, 8'hC0, "R3 ctrl readback");

        // R4 volatile access
        wr(4'd0, 8'h11);
        endt();
        chk_wipers("R4 volatile write", 7'h11, 7'h5A);
        rd(4'd8, 8'hC0, "R4 no commit");
        rd(4'd0, 8'h11, "R4 wiper read");
        wr(4'd8, 8'h40);
        rd(4'd0, 8'h25, "R4 stored untouched");

        // R5 / R7 stored channel write and commit timing
        wr(4'd1, 8'hF3);
        chk_wipers("R5 immediate wiper load", 7'h11, 7'h73);
        endt();
        rd(4'd8, 8'h60, "R7 busy after end");
        rd(4'd1, 8'h5A, "R7 old value during commit");
        repeat (COMMIT - 3) @(negedge clk);
        rd(4'd8, 8'h60, "R7 last busy cycle");
        rd(4'd8, 8'h40, "R7 busy cleared");
        rd(4'd1, 8'h73, "R5 stored value masked");

        // R8 writes refused during commit
        wr(4'd3, 8'hA5);
        endt();
        wr(4'd8, 8'h80);
        wr(4'd0, 8'h22);
        wr(4'd4, 8'h77);
        chk("R8 ctrl refused shutdown", {7'd0, shutdown}, 8'h00);
        chk_wipers("R8 wiper refused", 7'h11, 7'h73);
        rd(4'd8, 8'h60, "R8 ctrl unchanged");
        repeat (COMMIT) @(negedge clk);
        rd(4'd3, 8'hA5, "R6 gp committed");
        rd(4'd4, 8'h00, "R8 gp refused");
        rd(4'd0, 8'h25, "R8 stored ch0 refused");

        // R9 one stored write per transaction
        wr(4'd5, 8'h12);
        wr(4'd6, 8'h34);
        wr(4'd0, 8'h0F);
        chk_wipers("R9 later load ignored", 7'h11, 7'h73);
        endt();
        repeat (COMMIT + 2) @(negedge clk);
        rd(4'd5, 8'h12, "R9 first committed");
        rd(4'd6, 8'h00, "R9 second ignored");
        rd(4'd0, 8'h25, "R9 third ignored");

        // R6 gp bytes with select = 1
        wr(4'd8, 8'hC0);
        wr(4'd6, 8'hBE);
        endt();
        rd(4'd8, 8'hE0, "R6 commit with select set");
        repeat (COMMIT + 2) @(negedge clk);
        rd(4'd6, 8'hBE, "R6 gp readback");

        // R10 shutdown
        wr(4'd8, 8'h80);
        chk("R10 ctrl shutdown", {7'd0, shutdown}, 8'h01);
        chk_wipers("R10 grounded", 7'h00, 7'h00);
        wr(4'd1, 8'h44);
        chk_wipers("R10 still grounded", 7'h00, 7'h00);
        rd(4'd1, 8'h44, "R10 writable in shutdown");
        wr(4'd8, 8'hC0);
        chk_wipers("R10 restored", 7'h11, 7'h44);
        shdn_pin_n = 1'b0;
        #1;
        chk("R10 pin shutdown", {7'd0, shutdown}, 8'h01);
        chk_wipers("R10 pin grounded", 7'h00, 7'h00);
        @(negedge clk);
        shdn_pin_n = 1'b1;
        #1;
        chk_wipers("R10 pin restored", 7'h11, 7'h44);
        @(negedge clk);

        // R11 unmapped addresses
        wr(4'd7, 8'hFF);
        wr(4'd9, 8'hFF);
        endt();
        rd(4'd8, 8'hC0, "R11 no commit no ctrl change");
        rd(4'd7, 8'h00, "R11 addr 7");
        rd(4'd15, 8'h00, "R11 addr 15");
        @(negedge clk);
        chk("R12 idle", {7'd0, rd_valid}, 8'h00);

        finish_run();
    end
endmodule